// File: doc/BRIEF.md
# Dithered Sigma-Delta Multichannel PWM

This block drives sixteen single-bit outputs. Each output is a pulse-width modulator with a 256-clock period. Each channel holds a 16-bit level. The upper byte sets the base pulse width. The lower byte is a fractional residue. A first-order sigma-delta loop turns the residue into occasional one-count stretches of the pulse, so the average width has resolution finer than one counter step. At a 10 MHz clock the carrier sits near 40 kHz.

One sequencer visits the channels in turn. Each channel gets a 16-clock slot, so every channel is re-quantised once per period. The modulator arithmetic is therefore shared by all channels. One LFSR supplies dither to every channel. The bit 0 of the residue is discarded, which keeps the loop to half of its range and shortens the idle limit cycles. New pulse widths wait in a shadow register and are applied only when the counter wraps. A host writes levels through a simple write port, with a channel index, at any time.

Top module: `dith_sd_pwm`

## Requirements
- R1: The free-running counter has a 256-clock period, and counter value 0 starts each period. An output is high while the counter is below that channel's active duty, so the number of high clocks in a period equals the duty.
- R2: When bits [7:1] of a level are zero, the output is high for exactly the upper byte, in clocks, in every period.
- R3: Bit 0 of a level has no effect. A level of 0x4001 gives exactly 64 high clocks in every period.
- R4: Every period's duty is either the upper byte or the upper byte plus one. The number of stretched periods tracks the 7-bit residue (bits [7:1]) divided by 128. Over 64 periods with residue 96, the count of stretched periods is 47 to 49.
- R5: The modulator works as follows. Dither is bits [3:0] of a 16-bit Galois LFSR. The LFSR shifts right and XORs in 0xB400 when the bit shifted out is 1. It is seeded with 0xACE1 and advances once per channel slot. A carry occurs when accumulator + residue + dither ≥ 128. The accumulator keeps accumulator + residue, minus 128 on a carry. The accumulator stays within −15..127.
- R6: The active duty changes only at the counter wrap. A level written mid-period does not alter the pulse under way.
- R7: When the upper byte is 255, the duty stays 255 even when a carry occurs.
- R8: A duty of 0 keeps the output low for the whole period.
- R9: Channel k is updated when the counter is 16·k. A level written before that point in a period shows in the next period. A level written after it shows one period later.
- R10: A synchronous reset clears the levels, accumulators, shadow and active duties, and the counter. All outputs are then low.
- R11: All sixteen channels run at the same time and independently, each following its own level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| levelWrEn | input | 1 | Write strobe for a channel level |
| levelWrCh | input | 4 | Channel index for the write |
| levelWrData | input | 16 | New level: upper byte base duty, lower byte residue |
| pwmOut | output | 16 | One modulated output per channel |

## Verification
The assertions assume the following about the inputs. At most one level write occurs per clock. The channel index always names an existing channel, which holds by construction when the channel count is a power of two. Reset is held for at least one edge before any check is relied upon. The bench drives writes only at falling edges and only to the sixteen valid indices. It applies reset once at the start. It times mid-period and before-slot writes against its own copy of the counter, so every write lands at a known count.

// File: rtl/dith_sd_pwm_pkg.sv
package dith_sd_pwm_pkg;
  // Strobes from the sequencer to the datapath.
  typedef struct packed {
    logic updNow;      // first clock of a channel slot: re-quantise that channel
    logic loadActive;  // last clock of the period: shadow duties become active
  } seqStrobe_t;
endpackage

// File: rtl/dith_sd_pwm_ctrl.sv
module dith_sd_pwm_ctrl
  import dith_sd_pwm_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int CH_W  = 4
) (
  input  logic             clk,
  input  logic             rst,
  output logic [CNT_W-1:0] pwmCnt,
  output logic [CH_W-1:0]  slotCh,
  output seqStrobe_t       strobe
);
  localparam int SLOT_W = CNT_W - CH_W;

  always_ff @(posedge clk) begin
    if (rst) pwmCnt <= '0;
    else     pwmCnt <= pwmCnt + 1'b1;
  end

  assign slotCh            = pwmCnt[CNT_W-1 -: CH_W];
  assign strobe.updNow     = (pwmCnt[SLOT_W-1:0] == '0);
  assign strobe.loadActive = &pwmCnt;

  // R1: counter steps by one each clock and wraps
  assert_cnt_step_R1: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> pwmCnt == $past(pwmCnt) + 1'b1);

  // R9: one update per slot, never on back-to-back clocks
  assert_single_update_R9: assert property (@(posedge clk) disable iff (rst)
    strobe.updNow |=> !strobe.updNow);
endmodule

// File: rtl/dith_sd_pwm_datapath.sv
module dith_sd_pwm_datapath
  import dith_sd_pwm_pkg::*;
#(
  parameter int              CNT_W     = 8,
  parameter int              FRAC_W    = 8,
  parameter int              CH_W      = 4,
  parameter int              DITH_W    = 4,
  parameter int              LFSR_W    = 16,
  parameter logic [LFSR_W-1:0] LFSR_MASK = 16'hB400,
  parameter logic [LFSR_W-1:0] LFSR_SEED = 16'hACE1
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [CNT_W-1:0]         pwmCnt,
  input  logic [CH_W-1:0]          slotCh,
  input  seqStrobe_t               strobe,
  input  logic                     levelWrEn,
  input  logic [CH_W-1:0]          levelWrCh,
  input  logic [CNT_W+FRAC_W-1:0]  levelWrData,
  output logic [(1<<CH_W)-1:0]     pwmOut
);
  localparam int NUM_CH = 1 << CH_W;
  localparam int LVL_W  = CNT_W + FRAC_W;
  localparam int RES_W  = FRAC_W - 1;          // one residue bit given up
  localparam int ACC_W  = FRAC_W + 1;          // signed accumulator
  localparam int WIDE_W = ACC_W + 2;
  localparam int HALF   = 1 << RES_W;
  localparam int DMAX   = (1 << DITH_W) - 1;
  localparam logic [WIDE_W-1:0] HALF_V = WIDE_W'(HALF);

  logic [LVL_W-1:0]  level      [NUM_CH];
  logic [ACC_W-1:0]  acc        [NUM_CH];
  logic [CNT_W-1:0]  shadowDuty [NUM_CH];
  logic [CNT_W-1:0]  activeDuty [NUM_CH];
  logic [LFSR_W-1:0] lfsr;

  logic [LVL_W-1:0]  selLevel;
  logic [CNT_W-1:0]  base;
  logic [FRAC_W-1:0] fracPart;
  logic [WIDE_W-1:0] residExt, dithExt, partial, withDith, accWide;
  logic              carry;
  logic [CNT_W-1:0]  nextDuty;
  logic [LFSR_W-1:0] lfsrNext;

  // Shared modulator arithmetic for the channel owning the current slot.
  always_comb begin
    selLevel = level[slotCh];
    base     = selLevel[LVL_W-1 -: CNT_W];
    fracPart = selLevel[FRAC_W-1:0];
    residExt = {{(WIDE_W-FRAC_W){1'b0}}, fracPart} >> 1;
    dithExt  = {{(WIDE_W-DITH_W){1'b0}}, lfsr[DITH_W-1:0]};
    partial  = {{2{acc[slotCh][ACC_W-1]}}, acc[slotCh]} + residExt;
    withDith = partial + dithExt;
    carry    = !withDith[WIDE_W-1] && (withDith >= HALF_V);
    accWide  = carry ? (partial - HALF_V) : partial;
    nextDuty = (&base) ? base : base + CNT_W'(carry);
    lfsrNext = lfsr[0] ? ((lfsr >> 1) ^ LFSR_MASK) : (lfsr >> 1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_CH; i++) begin
        level[i]      <= '0;
        acc[i]        <= '0;
        shadowDuty[i] <= '0;
        activeDuty[i] <= '0;
      end
      lfsr <= LFSR_SEED;
    end else begin
      if (levelWrEn) level[levelWrCh] <= levelWrData;
      if (strobe.updNow) begin
        acc[slotCh]        <= accWide[ACC_W-1:0];
        shadowDuty[slotCh] <= nextDuty;
        lfsr               <= lfsrNext;
      end
      if (strobe.loadActive) activeDuty <= shadowDuty;
    end
  end

  for (genvar g = 0; g < NUM_CH; g++) begin : gCmp
    assign pwmOut[g] = (pwmCnt < activeDuty[g]);

    // R6: active duty is held for the whole period
    assert_active_hold_R6: assert property (@(posedge clk) disable iff (rst)
      (pwmCnt != '0) |-> $stable(activeDuty[g]));
  end

  // R5: the accumulator stays bounded by the dither depth and the half range
  assert_acc_bounded_R5: assert property (@(posedge clk) disable iff (rst)
    strobe.updNow |-> ($signed(accWide) >= -DMAX) && ($signed(accWide) <= HALF - 1));

  // R5: the shared dither source never locks up at zero
  assert_lfsr_alive_R5: assert property (@(posedge clk) disable iff (rst)
    lfsr != '0);

  // R4: a fresh duty is the base or one count above it
  assert_duty_step_R4: assert property (@(posedge clk) disable iff (rst)
    strobe.updNow |=> (shadowDuty[$past(slotCh)] == $past(base)) ||
                      (shadowDuty[$past(slotCh)] == $past(base) + 1'b1));
endmodule

// File: rtl/dith_sd_pwm.sv
module dith_sd_pwm
  import dith_sd_pwm_pkg::*;
#(
  parameter int CNT_W  = 8,
  parameter int FRAC_W = 8,
  parameter int CH_W   = 4,
  parameter int DITH_W = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    levelWrEn,
  input  logic [CH_W-1:0]         levelWrCh,
  input  logic [CNT_W+FRAC_W-1:0] levelWrData,
  output logic [(1<<CH_W)-1:0]    pwmOut
);
  logic [CNT_W-1:0] pwmCnt;
  logic [CH_W-1:0]  slotCh;
  seqStrobe_t       strobe;

  dith_sd_pwm_ctrl #(.CNT_W(CNT_W), .CH_W(CH_W)) uCtrl (
    .clk(clk), .rst(rst), .pwmCnt(pwmCnt), .slotCh(slotCh), .strobe(strobe)
  );

  dith_sd_pwm_datapath #(
    .CNT_W(CNT_W), .FRAC_W(FRAC_W), .CH_W(CH_W), .DITH_W(DITH_W)
  ) uData (
    .clk(clk), .rst(rst), .pwmCnt(pwmCnt), .slotCh(slotCh), .strobe(strobe),
    .levelWrEn(levelWrEn), .levelWrCh(levelWrCh), .levelWrData(levelWrData),
    .pwmOut(pwmOut)
  );
endmodule

// File: tb/dith_sd_pwm_test.sv
module dith_sd_pwm_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        levelWrEn = 1'b0;
  logic [3:0]  levelWrCh = '0;
  logic [15:0] levelWrData = '0;
  logic [15:0] pwmOut;

  int checks = 0, errors = 0, mism = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  dith_sd_pwm uut (.clk(clk), .rst(rst), .levelWrEn(levelWrEn),
                   .levelWrCh(levelWrCh), .levelWrData(levelWrData), .pwmOut(pwmOut));

  // Reference model written from the requirements (R1, R5, R6, R7, R9, R10)
  int mLvl[16], mAcc[16], mSh[16], mAct[16], mCnt;
  logic [15:0] mLfsr;
  always @(posedge clk) begin
    int k, r, d, t, c, b;
    if (rst) begin
      for (int i = 0; i < 16; i++) begin mLvl[i] = 0; mAcc[i] = 0; mSh[i] = 0; mAct[i] = 0; end
      mCnt = 0; mLfsr = 16'hACE1;
    end else begin
      if (mCnt % 16 == 0) begin
        k = mCnt / 16; r = (mLvl[k] & 255) >> 1; d = int'(mLfsr[3:0]);
        t = mAcc[k] + r; c = ((t + d) >= 128) ? 1 : 0;
        mAcc[k] = c ? t - 128 : t;
        b = mLvl[k] >> 8; mSh[k] = (b + c > 255) ? 255 : b + c;
        mLfsr = mLfsr[0] ? ((mLfsr >> 1) ^ 16'hB400) : (mLfsr >> 1);
      end
      if (mCnt == 255) for (int i = 0; i < 16; i++) mAct[i] = mSh[i];
      if (levelWrEn) mLvl[levelWrCh] = int'(levelWrData);
      mCnt = (mCnt + 1) % 256;
    end
  end

  always @(negedge clk)
    if (!rst)
      for (int i = 0; i < 16; i++)
        if (pwmOut[i] !== (mCnt < mAct[i])) mism++;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic writeLevel(input int ch, input int val);
    levelWrEn = 1'b1; levelWrCh = 4'(ch); levelWrData = 16'(val);
    @(negedge clk);
    levelWrEn = 1'b0;
  endtask

  task automatic waitCnt(input int v);
    do @(negedge clk); while (mCnt != v);
  endtask

  // Counts high clocks of one channel over the next whole period.
  task automatic measure(input int ch, output int hi);
    while (mCnt != 0) @(negedge clk);
    hi = 0;
    for (int i = 0; i < 256; i++) begin
      if (pwmOut[ch]) hi++;
      @(negedge clk);
    end
  endtask

  task automatic skipPeriods(input int n);
    int h;
    for (int i = 0; i < n; i++) measure(0, h);
  endtask

  task automatic tReset;
    int h;
    rst = 1'b1;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    check(pwmOut == 16'h0, "R10 outputs low after reset", int'(pwmOut), 0);
    mism = 0;
    measure(9, h);
    check(h == 0, "R10 no pulse after reset", h, 0);
  endtask

  task automatic tExact;
    int h;
    writeLevel(0, 16'h8000);
    writeLevel(1, 16'h4001);
    writeLevel(5, 16'h0000);
    skipPeriods(2);
    for (int p = 0; p < 3; p++) begin
      measure(0, h); check(h == 128, "R2 whole-step level exact", h, 128);
    end
    for (int p = 0; p < 3; p++) begin
      measure(1, h); check(h == 64, "R3 bit 0 ignored", h, 64);
    end
    measure(5, h); check(h == 0, "R8 zero duty low", h, 0);
    check(mism == 0, "R1 cycle match", mism, 0);
  endtask

  task automatic tSat;
    int h;
    writeLevel(7, 16'hFFFE);
    skipPeriods(2);
    for (int p = 0; p < 4; p++) begin
      measure(7, h); check(h == 255, "R7 saturated duty", h, 255);
    end
    check(mism == 0, "R5 modulator sequence", mism, 0);
  endtask

  task automatic tAverage;
    int h, tot = 0, lo = 999, hiMax = 0, stretched;
    writeLevel(3, 16'h40C0);
    skipPeriods(2);
    for (int p = 0; p < 64; p++) begin
      measure(3, h);
      tot += h;
      if (h < lo) lo = h;
      if (h > hiMax) hiMax = h;
    end
    stretched = tot - 64 * 64;
    check(lo >= 64 && hiMax <= 65, "R4 duty is base or base+1", hiMax, 65);
    check(stretched >= 47 && stretched <= 49, "R4 stretch count", stretched, 48);
    check(mism == 0, "R5 modulator sequence", mism, 0);
  endtask

  task automatic tMidWrite;
    int h = 0, h2;
    writeLevel(4, 16'h2000);
    skipPeriods(2);
    while (mCnt != 0) @(negedge clk);
    for (int i = 0; i < 256; i++) begin
      if (pwmOut[4]) h++;
      if (mCnt == 100) begin
        levelWrEn = 1'b1; levelWrCh = 4'd4; levelWrData = 16'hC000;
      end else levelWrEn = 1'b0;
      @(negedge clk);
    end
    levelWrEn = 1'b0;
    check(h == 32, "R6 pulse under way unchanged", h, 32);
    measure(4, h2); check(h2 == 32, "R9 write after slot waits a period", h2, 32);
    measure(4, h2); check(h2 == 192, "R9 late write applied", h2, 192);
  endtask

  task automatic tEarlyWrite;
    int h;
    writeLevel(2, 16'h3000);
    skipPeriods(2);
    waitCnt(10);
    writeLevel(2, 16'h5000);
    measure(2, h); check(h == 80, "R9 write before slot next period", h, 80);
  endtask

  task automatic tAllChannels;
    int h;
    for (int c = 0; c < 16; c++) writeLevel(c, c * 16'h0F00 + c * 16'h0013);
    mism = 0;
    skipPeriods(8);
    check(mism == 0, "R11 all channels match model", mism, 0);
    writeLevel(14, 16'h6A00);
    skipPeriods(2);
    measure(14, h); check(h == 106, "R11 channel independent", h, 106);
    check(mism == 0, "R5 modulator sequence", mism, 0);
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    tReset();
    tExact();
    tSat();
    tAverage();
    tMidWrite();
    tEarlyWrite();
    tAllChannels();
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule